// File: doc/BRIEF.md
# UART Receive FIFO with Status Registers

This block buffers bytes arriving from a UART deserializer and hands them to software through a small word-addressed register port. A byte offered on the push interface is stored in a byte-wide FIFO when queueing is switched on. Each read of the receive-data word pops one entry. When queueing is switched off, the block keeps only one holding register, which the next byte overwrites.

The status words report the queue occupancy, a full flag, a sticky overflow flag, a data-ready bit and the accumulated line errors. A line-break event is entered as a zero byte and is flagged in the error word. The error word clears itself when software reads it. Two single-cycle strobes, one for a stored byte and one for an error, feed a separate interrupt block. A control write can flush the queue. The queue depth is a parameter and defaults to 16.

Register word addresses on `reg_addr`: 0 control, 1 FIFO status, 2 data-ready status, 3 error status, 4 receive data. Reads of any other address return zero.

Top module: `rxq_top`

## Requirements
- R1: After reset, the control word reads 0 (queueing off), the FIFO status word reads 0, the data-ready status word reads 0x6 (bits 2:1 always read 1, bit 0 is data-ready), the error word reads 0, and both strobes are low.
- R2: With queueing on (control bit 0 = 1), bytes read from the receive-data word come back in push order, with the data in `reg_rdata` one cycle after `reg_rd`. Data-ready (bit 0 of word 2) stays 1 while entries remain and reads 0 once the last entry has been popped.
- R3: The FIFO status word holds the occupancy in bits 7:0 and a full flag in bit 8. When the queue holds DEPTH entries, bit 8 reads 1 and bits 7:0 read 0.
- R4: A push into a full queue with no pop in the same cycle is dropped, and the stored entries are unchanged. One cycle later `ev_err` pulses, bit 9 (sticky overflow) of the FIFO status word is set, and overrun (bit 0 of the error word) is set.
- R5: A receive-data read with queueing on and the queue empty returns 0, pulses `ev_err` one cycle later and leaves the occupancy unchanged.
- R6: A push and a pop in the same cycle leave the occupancy unchanged. This also holds when the queue is full: the pop frees the slot that the push then fills.
- R7: With queueing off, a pushed byte goes into one holding register and sets data-ready. A receive-data read returns that byte and clears data-ready. A push while the held byte is still unread overwrites it and sets overrun (error bit 0).
- R8: A `line_break` pulse enters a zero byte and sets bit 3 of the error word. Any `push_data` or `push_flags` offered in the same cycle are ignored.
- R9: `push_flags` bits 0 (overrun), 1 (parity) and 2 (frame) are added to error word bits 0, 1 and 2. A read of the error word returns its value and then clears it, except for bits raised in the same cycle as the read, which remain set.
- R10: Writing control bit 1 empties the queue and clears the sticky overflow flag. Control bits 1 and 2 always read back 0. Bit 0, the RX level field (bits 6:4) and the TX level field (bits 10:8) read back as written.
- R11: `ev_rx` pulses for one cycle, one cycle after each byte that is stored in the queue or in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A received byte is offered this cycle |
| push_data | input | 8 | Received byte |
| push_flags | input | 3 | Line errors of the byte: bit 0 overrun, bit 1 parity, bit 2 frame |
| line_break | input | 1 | Line-break event; enters a zero byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 11 | Write data (only the control word is writable) |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ev_rx | output | 1 | Byte-stored strobe |
| ev_err | output | 1 | Overflow or empty-read strobe |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause. Read data, popped bytes, `ev_rx` and `ev_err` are all registered at the edge where the request is taken. The bench drives each request on a falling edge, removes it on the next falling edge and samples the outputs at that same moment. The simultaneous cases (push with pop, push with an error-word read) are driven within one cycle, so that the same-edge ordering rules of R6 and R9 are what decides the expected value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W = 3;
  localparam int WDAT_W = 11;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FSTAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RDY    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERRS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXDATA = 3'd4;

  localparam int CB_EN    = 0;
  localparam int CB_RXCLR = 1;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic       ovr;
  } err_bits_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-before-write on a shared address: a full queue popped and pushed
  // in one cycle returns the old entry
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          accept,
  output logic          pop_ok,
  output logic          drop,
  output logic [PW-1:0] waddr,
  output logic [PW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wnxt, rnxt;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign pop_ok = pop_req & ~empty;
  assign accept = push_req & ~clr & (~full | pop_ok);
  assign drop   = push_req & ~clr & ~accept;

  if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
    assign wnxt = waddr + PW'(1);
    assign rnxt = raddr + PW'(1);
  end else begin : g_wrap
    assign wnxt = (waddr == PW'(DEPTH - 1)) ? '0 : waddr + PW'(1);
    assign rnxt = (raddr == PW'(DEPTH - 1)) ? '0 : raddr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
    end else begin
      if (accept) waddr <= wnxt;
      if (pop_ok) raddr <= rnxt;
      case ({accept, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WDAT_W-1:0] reg_wdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              line_break,
  input  logic              push_valid,
  input  logic [2:0]        push_flags,
  input  logic [CW-1:0]     fifo_count,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              accept,
  input  logic              drop,
  input  logic [7:0]        mem_q,
  output logic              fifo_en,
  output logic              rx_clr,
  output logic              push_req,
  output logic              pop_req,
  output logic [3:0]        err_stat,
  output logic [31:0]       reg_rdata,
  output logic              ev_rx,
  output logic              ev_err
);
  logic       en_q;
  logic [2:0] rxlvl_q, txlvl_q;
  logic       ovf_q;
  logic [7:0] hold_q;
  logic       hold_full_q;
  err_bits_t  err_q, err_set;
  logic       rsel_q;
  logic [31:0] csr_q;

  logic wr_ctrl, rd_data, rd_err, byp_push, byp_rd, byp_ovr, empty_rd, drdy;
  logic [7:0]  cnt_field;
  logic [31:0] ctrl_word, fstat_word, rdy_word, rd_word;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign rx_clr   = wr_ctrl && reg_wdata[CB_RXCLR];
  assign rd_data  = reg_rd && (reg_addr == A_RXDATA);
  assign rd_err   = reg_rd && (reg_addr == A_ERRS);
  assign fifo_en  = en_q;
  assign push_req = in_valid & en_q;
  assign pop_req  = rd_data & en_q;
  assign byp_push = in_valid & ~en_q;
  assign byp_rd   = rd_data & ~en_q;
  assign byp_ovr  = byp_push & hold_full_q & ~byp_rd;
  assign empty_rd = pop_req & fifo_empty;
  assign drdy     = en_q ? ~fifo_empty : hold_full_q;
  assign err_stat = err_q;

  always_comb begin
    err_set = '0;
    if (line_break) begin
      err_set.brk = 1'b1;
    end else if (push_valid) begin
      err_set.ovr = push_flags[0];
      err_set.par = push_flags[1];
      err_set.frm = push_flags[2];
    end
    if (drop || byp_ovr) err_set.ovr = 1'b1;
  end

  assign cnt_field  = fifo_full ? 8'd0 : 8'(fifo_count);
  assign ctrl_word  = {21'd0, txlvl_q, 1'b0, rxlvl_q, 3'b000, en_q};
  assign fstat_word = {7'd0, 1'b0, 8'd0, 6'd0, ovf_q, fifo_full, cnt_field};
  assign rdy_word   = {29'd0, 2'b11, drdy};

  always_comb begin
    case (reg_addr)
      A_CTRL:   rd_word = ctrl_word;
      A_FSTAT:  rd_word = fstat_word;
      A_RDY:    rd_word = rdy_word;
      A_ERRS:   rd_word = {28'd0, err_q};
      A_RXDATA: rd_word = en_q ? 32'd0 : {24'd0, hold_q};
      default:  rd_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      rxlvl_q     <= '0;
      txlvl_q     <= '0;
      ovf_q       <= 1'b0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      err_q       <= '0;
      rsel_q      <= 1'b0;
      csr_q       <= '0;
      ev_rx       <= 1'b0;
      ev_err      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[CB_EN];
        rxlvl_q <= reg_wdata[6:4];
        txlvl_q <= reg_wdata[10:8];
      end
      if (rx_clr)    ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;

      if (byp_push) begin
        hold_q      <= in_data;
        hold_full_q <= 1'b1;
      end else if (byp_rd) begin
        hold_full_q <= 1'b0;
      end

      if (rd_err) err_q <= err_set;
      else        err_q <= err_q | err_set;

      if (reg_rd) begin
        rsel_q <= pop_req & ~fifo_empty;
        csr_q  <= rd_word;
      end
      ev_rx  <= accept | byp_push;
      ev_err <= drop | empty_rd;
    end
  end

  assign reg_rdata = rsel_q ? {24'd0, mem_q} : csr_q;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  input  logic [2:0]        push_flags,
  input  logic              line_break,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WDAT_W-1:0] reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ev_rx,
  output logic              ev_err
);
  logic          in_valid;
  logic [7:0]    in_data;
  logic          fifo_en, rx_clr, push_req, pop_req;
  logic          accept, pop_ok, drop, fifo_full, fifo_empty;
  logic [PW-1:0] waddr, raddr;
  logic [CW-1:0] fifo_count;
  logic [7:0]    mem_q;
  logic [3:0]    err_stat;

  // a break wins over a byte offered in the same cycle and enters zero
  assign in_valid = push_valid | line_break;
  assign in_data  = line_break ? 8'd0 : push_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .clr(rx_clr), .push_req(push_req), .pop_req(pop_req),
    .accept(accept), .pop_ok(pop_ok), .drop(drop), .waddr(waddr), .raddr(raddr),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .we(accept), .waddr(waddr), .wdata(in_data),
    .re(pop_ok), .raddr(raddr), .rdata(mem_q)
  );

  rxq_csr #(.DEPTH(DEPTH)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_data(in_data),
    .line_break(line_break), .push_valid(push_valid), .push_flags(push_flags),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .accept(accept), .drop(drop), .mem_q(mem_q), .fifo_en(fifo_en),
    .rx_clr(rx_clr), .push_req(push_req), .pop_req(pop_req), .err_stat(err_stat),
    .reg_rdata(reg_rdata), .ev_rx(ev_rx), .ev_err(ev_err)
  );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              ev_rx,
  input logic              ev_err,
  input logic              push_valid,
  input logic              line_break,
  input logic [CW-1:0]     fifo_count,
  input logic              fifo_full,
  input logic              fifo_en,
  input logic              fifo_empty,
  input logic              accept,
  input logic              pop_ok,
  input logic              rx_clr,
  input logic [3:0]        err_stat
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  p_full_field_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_FSTAT) |=> (!reg_rdata[8] || reg_rdata[7:0] == 8'd0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop_ok && !rx_clr) |=> $stable(fifo_count));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && fifo_empty && reg_rd && reg_addr == A_RXDATA)
      |=> (ev_err && reg_rdata == 32'd0));

  p_pushpop_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && pop_ok && !rx_clr) |=> $stable(fifo_count));

  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_ERRS && !push_valid && !line_break) |=> (err_stat == 4'd0));

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> fifo_empty);

  p_ctrl_selfclr_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_CTRL) |=> (reg_rdata[2:1] == 2'b00));

  p_rx_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    accept |=> ev_rx);
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ev_rx(ev_rx), .ev_err(ev_err), .push_valid(push_valid), .line_break(line_break),
  .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_en(fifo_en),
  .fifo_empty(fifo_empty), .accept(accept), .pop_ok(pop_ok), .rx_clr(rx_clr),
  .err_stat(err_stat)
);

// File: tb/rxq_top_test.sv
module rxq_top_test;
  localparam int DEPTH = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_FSTAT = 3'd1, A_RDY = 3'd2,
                         A_ERRS = 3'd3, A_RXDATA = 3'd4;
  // {byte pushed, expected occupancy afterwards}
  localparam logic [15:0] VEC [8] = '{
    {8'hA1, 8'd1}, {8'h5B, 8'd2}, {8'h00, 8'd3}, {8'hFF, 8'd4},
    {8'h3C, 8'd5}, {8'h81, 8'd6}, {8'h7E, 8'd7}, {8'h12, 8'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic [2:0]  push_flags = '0;
  logic        line_break = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_rx, ev_err;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  rxq_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_flags(push_flags), .line_break(line_break), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_rx(ev_rx), .ev_err(ev_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; e = ev_err;
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] f, input logic brk,
                      output logic r, output logic e);
    @(negedge clk); push_valid = 1'b1; push_data = b; push_flags = f; line_break = brk;
    @(negedge clk); push_valid = 1'b0; push_flags = '0; line_break = 1'b0;
    r = ev_rx; e = ev_err;
  endtask

  task automatic pushpop(input logic [7:0] b, output logic [31:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = b; reg_rd = 1'b1; reg_addr = A_RXDATA;
    @(negedge clk); push_valid = 1'b0; reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e, r;
    logic [7:0] fill [DEPTH];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 strobes", {30'd0, ev_rx, ev_err}, 32'd0);
    rd(A_CTRL, d, e);  chk("R1 ctrl", d, 32'd0);
    rd(A_FSTAT, d, e); chk("R1 fstat", d, 32'd0);
    rd(A_RDY, d, e);   chk("R1 rdy", d, 32'h6);
    rd(A_ERRS, d, e);  chk("R1 errs", d, 32'd0);

    // R7 holding register (queueing off after reset)
    push(8'h3C, 3'b000, 1'b0, r, e); chk("R11 bypass ev_rx", {31'd0, r}, 32'd1);
    rd(A_RDY, d, e); chk("R7 ready set", d, 32'h7);
    push(8'h7E, 3'b000, 1'b0, r, e);
    rd(A_RXDATA, d, e); chk("R7 overwrite data", d, 32'h7E);
    rd(A_RDY, d, e);    chk("R7 ready cleared", d, 32'h6);
    rd(A_ERRS, d, e);   chk("R7 overrun", d, 32'h1);
    rd(A_ERRS, d, e);   chk("R9 clear on read", d, 32'h0);

    // R10 control readback
    wr(A_CTRL, 11'h537);
    rd(A_CTRL, d, e); chk("R10 ctrl readback", d, 32'h531);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][15:8], 3'b000, 1'b0, r, e);
      chk("R11 ev_rx", {31'd0, r}, 32'd1);
      rd(A_FSTAT, d, e); chk("R3 count", d, {24'd0, VEC[i][7:0]});
    end
    for (int i = 0; i < 8; i++) begin
      rd(A_RXDATA, d, e); chk("R2 order", d, {24'd0, VEC[i][15:8]});
      if (i >= 6) begin
        rd(A_RDY, d, e); chk("R2 ready", d, (i == 7) ? 32'h6 : 32'h7);
      end
    end

    // R3 R4 full and overflow
    for (int i = 0; i < DEPTH; i++) begin
      fill[i] = 8'(i * 13 + 7);
      push(fill[i], 3'b000, 1'b0, r, e);
    end
    rd(A_FSTAT, d, e); chk("R3 full field", d, 32'h100);
    push(8'hEE, 3'b000, 1'b0, r, e);
    chk("R4 ev_err", {31'd0, e}, 32'd1);
    chk("R4 no ev_rx", {31'd0, r}, 32'd0);
    rd(A_FSTAT, d, e); chk("R4 sticky flag", d, 32'h300);
    rd(A_ERRS, d, e);  chk("R4 overrun", d, 32'h1);

    // R6 push and pop on a full queue
    pushpop(8'h99, d); chk("R6 full pushpop data", d, {24'd0, fill[0]});
    rd(A_FSTAT, d, e); chk("R6 full count kept", d, 32'h300);
    for (int i = 1; i < DEPTH; i++) begin
      rd(A_RXDATA, d, e); chk("R4 contents kept", d, {24'd0, fill[i]});
    end
    rd(A_RXDATA, d, e); chk("R6 pushed byte", d, 32'h99);

    // R5 empty read
    rd(A_RXDATA, d, e);
    chk("R5 zero data", d, 32'd0);
    chk("R5 ev_err", {31'd0, e}, 32'd1);
    rd(A_FSTAT, d, e); chk("R5 count kept", d, 32'h200);

    // R10 flush
    push(8'h01, 3'b000, 1'b0, r, e);
    push(8'h02, 3'b000, 1'b0, r, e);
    wr(A_CTRL, 11'h533);
    rd(A_FSTAT, d, e); chk("R10 flushed", d, 32'h0);
    rd(A_RDY, d, e);   chk("R10 ready low", d, 32'h6);

    // R6 push and pop with one entry
    push(8'h42, 3'b000, 1'b0, r, e);
    pushpop(8'h43, d); chk("R6 pushpop data", d, 32'h42);
    rd(A_FSTAT, d, e); chk("R6 count kept", d, 32'h1);
    rd(A_RXDATA, d, e); chk("R6 second byte", d, 32'h43);

    // R8 break beats a byte in the same cycle
    push(8'h55, 3'b111, 1'b1, r, e);
    chk("R8 break stored", {31'd0, r}, 32'd1);
    rd(A_ERRS, d, e);   chk("R8 break bit", d, 32'h8);
    rd(A_ERRS, d, e);   chk("R9 cleared", d, 32'h0);
    rd(A_RXDATA, d, e); chk("R8 zero byte", d, 32'h0);
    rd(A_FSTAT, d, e);  chk("R8 single entry", d, 32'h0);

    // R9 flags and a raise during the clearing read
    push(8'h10, 3'b001, 1'b0, r, e);
    @(negedge clk); push_valid = 1'b1; push_data = 8'h11; push_flags = 3'b010;
    reg_rd = 1'b1; reg_addr = A_ERRS;
    @(negedge clk); push_valid = 1'b0; push_flags = '0; reg_rd = 1'b0; d = reg_rdata;
    chk("R9 read old value", d, 32'h1);
    rd(A_ERRS, d, e); chk("R9 raised bit kept", d, 32'h2);
    push(8'h12, 3'b100, 1'b0, r, e);
    rd(A_ERRS, d, e); chk("R9 frame bit", d, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule